// File: doc/BRIEF.md
# Machine-Mode Trap and Return Controller

This block holds the machine-level trap state of a simple in-order core and decides, each cycle, whether the pipeline is redirected. An interrupt request is sampled against the instruction currently in the memory stage. If the request is accepted, the controller records the PC of the oldest instruction that has not committed yet as the return address. It saves the current privilege and interrupt-enable bit, enters machine mode with interrupts masked, and steers fetch to one fixed handler address. A return-from-trap instruction that reaches the memory stage reverses this. Fetch is sent back to the saved return address, the privilege and enable bit come back from their saved copies, and the saved copies are reset to their idle values.

Either event raises a flush for the younger stages in the same cycle as the redirect. A small write port lets handler software load the return address or the saved status fields. That port is overridden whenever a trap or a return happens in the same cycle.

Top module: `mtrap_ctrl`

## Requirements
- R1: After reset the privilege is machine (2'b11), the enable bit, the saved enable bit, the saved privilege (2'b00) and the return address are all zero, and no redirect or flush is raised.
- R2: An interrupt is taken only when the request line, the memory-stage valid and the enable bit are all 1. Otherwise the request causes no redirect, no flush and no state change.
- R3: In the cycle a trap is taken, redirect valid and flush are 1 and the redirect target is the parameter TRAP_VEC.
- R4: A taken trap loads the return address with the memory-stage PC (epc_i) at the next clock edge.
- R5: A taken trap copies the privilege into the saved privilege and the enable bit into the saved enable bit, clears the enable bit and sets privilege to machine (2'b11).
- R6: A return that is valid and not overridden by a trap raises redirect valid and flush in that cycle, with the current return address as the target.
- R7: A return sets privilege to the saved privilege and the enable bit to the saved enable bit. It then sets the saved enable bit to 1 and the saved privilege to user (2'b00).
- R8: When a trap and a return are both presented in one cycle, only the trap is performed.
- R9: The write port stores the full word into the return address when select is 0. When select is 1 it stores the enable bit from data bit 3, the saved enable bit from bit 7 and the saved privilege from bits 12:11, with the reserved code 2'b10 stored as 2'b00. Other selects change nothing, and any write is ignored in a cycle that takes a trap or a return.
- R10: A return indication while the memory-stage valid is 0 has no effect on outputs or state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 1 | Interrupt request line |
| mem_valid_i | input | 1 | Memory stage holds an uncommitted instruction |
| epc_i | input | XLEN | PC of the oldest uncommitted instruction |
| mret_i | input | 1 | Return-from-trap is in the memory stage |
| csr_we_i | input | 1 | Write port enable |
| csr_sel_i | input | 2 | Write target: 0 return address, 1 status fields |
| csr_wdata_i | input | XLEN | Write data |
| redirect_valid_o | output | 1 | Fetch redirect this cycle |
| redirect_pc_o | output | XLEN | Redirect target |
| flush_o | output | 1 | Flush younger stages this cycle |
| priv_o | output | 2 | Current privilege |
| mepc_o | output | XLEN | Saved return address |
| mie_o | output | 1 | Interrupt enable |
| mpie_o | output | 1 | Saved interrupt enable |
| mpp_o | output | 2 | Saved privilege |

## Verification
The hardest case to reach is an interrupt that lands on a return in a chosen privilege with chosen saved fields, while a software write is also pending. Privilege can only be changed by a return, so the bench first loads the saved privilege through the write port and retires a return to land in the wanted mode. It then rewrites the status fields and the return address to the case under test. Finally it presents every mix of request, valid, return and write. All three privilege levels, both enable values, both saved-enable values and all four written saved-privilege codes are swept.

// File: rtl/mtrap_pkg.sv
// Package: shared privilege codes, status field positions and a field
// legalising helper for the machine trap controller.
// Assumes status words are at least 13 bits wide.
package mtrap_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'b00,
        PRIV_SUPER = 2'b01,
        PRIV_MACH  = 2'b11
    } priv_e;

    localparam int STAT_IE_BIT   = 3;
    localparam int STAT_PIE_BIT  = 7;
    localparam int STAT_PP_LO    = 11;
    localparam int STAT_PP_HI    = 12;

    localparam logic [1:0] SEL_EPC    = 2'd0;
    localparam logic [1:0] SEL_STATUS = 2'd1;

    // Map the reserved privilege code onto user mode.
    function automatic logic [1:0] legal_priv(input logic [1:0] code);
        return (code == 2'b10) ? PRIV_USER : code;
    endfunction

endpackage

// File: rtl/mtrap_arbiter.sv
// Module: decides which event wins this cycle. A trap beats a return,
// and both beat a software write.
// Assumes all inputs are stable around the clock edge; purely combinational
// apart from the clocked checks.
module mtrap_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    input  logic valid_i,
    input  logic mret_i,
    input  logic we_i,
    input  logic mie_i,
    output logic trap_take_o,
    output logic mret_take_o,
    output logic wr_en_o
);

    // Event priority: trap, then return, then write.
    always_comb begin
        trap_take_o = irq_i && valid_i && mie_i;
        mret_take_o = mret_i && valid_i && !trap_take_o;
        wr_en_o     = we_i && !trap_take_o && !mret_take_o;
    end

    // R2: a trap is only accepted with interrupts enabled and a live instruction.
    a_r2_trap_gated: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take_o |-> (mie_i && irq_i && valid_i));

    // R8: at most one architectural event per cycle.
    a_r8_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_take_o, mret_take_o, wr_en_o}));

    // R10: no return without a valid memory-stage instruction.
    a_r10_mret_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        mret_take_o |-> valid_i);

endmodule

// File: rtl/mtrap_csr.sv
// Module: the trap state registers (privilege, enable, saved enable,
// saved privilege, return address) and their update rules.
// Assumes at most one of trap_i, mret_i, wr_en_i is high in a cycle.
module mtrap_csr
    import mtrap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_i,
    input  logic            mret_i,
    input  logic            wr_en_i,
    input  logic [1:0]      wr_sel_i,
    input  logic [XLEN-1:0] wr_data_i,
    input  logic [XLEN-1:0] epc_i,
    output logic [1:0]      priv_o,
    output logic            mie_o,
    output logic            mpie_o,
    output logic [1:0]      mpp_o,
    output logic [XLEN-1:0] mepc_o
);

    logic [1:0]      priv_q;
    logic            ie_q;
    logic            pie_q;
    logic [1:0]      pp_q;
    logic [XLEN-1:0] epc_q;

    // Apply reset, trap entry, trap return or a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_q <= PRIV_MACH;
            ie_q   <= 1'b0;
            pie_q  <= 1'b0;
            pp_q   <= PRIV_USER;
            epc_q  <= '0;
        end else if (trap_i) begin
            epc_q  <= epc_i;
            pp_q   <= priv_q;
            pie_q  <= ie_q;
            ie_q   <= 1'b0;
            priv_q <= PRIV_MACH;
        end else if (mret_i) begin
            priv_q <= pp_q;
            ie_q   <= pie_q;
            pie_q  <= 1'b1;
            pp_q   <= PRIV_USER;
        end else if (wr_en_i) begin
            if (wr_sel_i == SEL_EPC) begin
                epc_q <= wr_data_i;
            end else if (wr_sel_i == SEL_STATUS) begin
                ie_q  <= wr_data_i[STAT_IE_BIT];
                pie_q <= wr_data_i[STAT_PIE_BIT];
                pp_q  <= legal_priv(wr_data_i[STAT_PP_HI:STAT_PP_LO]);
            end
        end
    end

    // Drive the register values out.
    always_comb begin
        priv_o = priv_q;
        mie_o  = ie_q;
        mpie_o = pie_q;
        mpp_o  = pp_q;
        mepc_o = epc_q;
    end

    // R4: the return address captures the memory-stage PC on a trap.
    a_r4_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
        trap_i |=> (epc_q == $past(epc_i)));

    // R5: trap entry saves state, masks interrupts and enters machine mode.
    a_r5_trap_entry: assert property (@(posedge clk) disable iff (!rst_n)
        trap_i |=> (priv_q == PRIV_MACH && !ie_q &&
                    pie_q == $past(ie_q) && pp_q == $past(priv_q)));

    // R7: return restores state and parks the saved copies.
    a_r7_return: assert property (@(posedge clk) disable iff (!rst_n)
        mret_i |=> (priv_q == $past(pp_q) && ie_q == $past(pie_q) &&
                    pie_q && pp_q == PRIV_USER));

    // R9: the saved privilege never holds the reserved code.
    a_r9_pp_legal: assert property (@(posedge clk) disable iff (!rst_n)
        pp_q != 2'b10);

    // R9: the return address moves only on a trap or a select-0 write.
    a_r9_epc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_i && !(wr_en_i && wr_sel_i == SEL_EPC)) |=> $stable(epc_q));

endmodule

// File: rtl/mtrap_redirect.sv
// Module: forms the fetch redirect and the one-cycle flush from the
// winning event.
// Assumes trap_i and mret_i are never high together.
module mtrap_redirect #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] TRAP_VEC = '0
) (
    input  logic            trap_i,
    input  logic            mret_i,
    input  logic [XLEN-1:0] mepc_i,
    output logic            redirect_valid_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic            flush_o
);

    // Choose the fetch target and raise the flush with it.
    always_comb begin
        redirect_valid_o = trap_i || mret_i;
        flush_o          = trap_i || mret_i;
        redirect_pc_o    = trap_i ? TRAP_VEC : (mret_i ? mepc_i : '0);
    end

endmodule

// File: rtl/mtrap_ctrl.sv
// Module: top of the machine trap controller. It joins the event arbiter,
// the trap state registers and the redirect logic.
// Assumes the pipeline presents the oldest uncommitted PC in epc_i whenever
// mem_valid_i is high; synchronous active-low reset.
module mtrap_ctrl
    import mtrap_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] TRAP_VEC = 32'h0000_0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_i,
    input  logic            mem_valid_i,
    input  logic [XLEN-1:0] epc_i,
    input  logic            mret_i,
    input  logic            csr_we_i,
    input  logic [1:0]      csr_sel_i,
    input  logic [XLEN-1:0] csr_wdata_i,
    output logic            redirect_valid_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic            flush_o,
    output logic [1:0]      priv_o,
    output logic [XLEN-1:0] mepc_o,
    output logic            mie_o,
    output logic            mpie_o,
    output logic [1:0]      mpp_o
);

    logic trap_take;
    logic mret_take;
    logic wr_en;

    mtrap_arbiter u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_i       (irq_i),
        .valid_i     (mem_valid_i),
        .mret_i      (mret_i),
        .we_i        (csr_we_i),
        .mie_i       (mie_o),
        .trap_take_o (trap_take),
        .mret_take_o (mret_take),
        .wr_en_o     (wr_en)
    );

    mtrap_csr #(.XLEN(XLEN)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .trap_i    (trap_take),
        .mret_i    (mret_take),
        .wr_en_i   (wr_en),
        .wr_sel_i  (csr_sel_i),
        .wr_data_i (csr_wdata_i),
        .epc_i     (epc_i),
        .priv_o    (priv_o),
        .mie_o     (mie_o),
        .mpie_o    (mpie_o),
        .mpp_o     (mpp_o),
        .mepc_o    (mepc_o)
    );

    mtrap_redirect #(.XLEN(XLEN), .TRAP_VEC(TRAP_VEC)) u_redir (
        .trap_i           (trap_take),
        .mret_i           (mret_take),
        .mepc_i           (mepc_o),
        .redirect_valid_o (redirect_valid_o),
        .redirect_pc_o    (redirect_pc_o),
        .flush_o          (flush_o)
    );

    // R3: an accepted interrupt redirects to the vector and flushes.
    a_r3_trap_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i && mem_valid_i && mie_o) |->
            (redirect_valid_o && flush_o && redirect_pc_o == TRAP_VEC));

    // R6: an unopposed valid return redirects to the saved address.
    a_r6_mret_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (mret_i && mem_valid_i && !(irq_i && mie_o)) |->
            (redirect_valid_o && flush_o && redirect_pc_o == mepc_o));

    // R2: with no instruction in the memory stage nothing is redirected.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid_i |-> (!redirect_valid_o && !flush_o));

    // R1: the first cycle after reset is in machine mode with interrupts off.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (priv_o == PRIV_MACH && !mie_o && !mpie_o && mpp_o == PRIV_USER));

endmodule

// File: tb/mtrap_ctrl_tb.sv
// Bench: sweeps privilege, status fields and every event mix, with a
// reference model of the trap state kept in the bench.
module mtrap_ctrl_tb;

    localparam int          XLEN = 32;
    localparam logic [31:0] VEC  = 32'h0000_0100;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            irq, vld, mret, we;
    logic [1:0]      sel;
    logic [XLEN-1:0] wdata, epc;
    logic            rv, fl, mie, mpie;
    logic [XLEN-1:0] rpc, mepc;
    logic [1:0]      priv, mpp;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // Reference model state.
    logic [1:0]  e_priv, e_mpp;
    logic        e_mie, e_mpie;
    logic [31:0] e_mepc;

    always #2 clk = ~clk;

    mtrap_ctrl #(.XLEN(XLEN), .TRAP_VEC(VEC)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .mem_valid_i(vld), .epc_i(epc),
        .mret_i(mret), .csr_we_i(we), .csr_sel_i(sel), .csr_wdata_i(wdata),
        .redirect_valid_o(rv), .redirect_pc_o(rpc), .flush_o(fl),
        .priv_o(priv), .mepc_o(mepc), .mie_o(mie), .mpie_o(mpie), .mpp_o(mpp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk({req, " priv"}, {30'd0, priv}, {30'd0, e_priv});
        chk({req, " mie"},  {31'd0, mie},  {31'd0, e_mie});
        chk({req, " mpie"}, {31'd0, mpie}, {31'd0, e_mpie});
        chk({req, " mpp"},  {30'd0, mpp},  {30'd0, e_mpp});
        chk({req, " mepc"}, mepc, e_mepc);
    endtask

    // One cycle: drive, check redirect outputs, clock, update model, check state.
    task automatic step(input logic i_irq, input logic i_vld, input logic i_mret,
                        input logic i_we, input logic [1:0] i_sel,
                        input logic [31:0] i_wd, input logic [31:0] i_epc);
        logic t, m, w;
        string tag;
        @(negedge clk);
        irq = i_irq; vld = i_vld; mret = i_mret; we = i_we;
        sel = i_sel; wdata = i_wd; epc = i_epc;
        #1;
        t = i_irq && i_vld && e_mie;
        m = i_mret && i_vld && !t;
        w = i_we && !t && !m;
        if (t && i_mret)            tag = "R8";
        else if (t)                 tag = "R3";
        else if (m)                 tag = "R6";
        else if (i_mret && !i_vld)  tag = "R10";
        else                        tag = "R2";
        chk({tag, " redirect"}, {31'd0, rv}, {31'd0, t || m});
        chk({tag, " flush"},    {31'd0, fl}, {31'd0, t || m});
        if (t)      chk({tag, " target"}, rpc, VEC);
        else if (m) chk({tag, " target"}, rpc, e_mepc);
        @(posedge clk);
        #1;
        if (t) begin
            e_mepc = i_epc; e_mpp = e_priv; e_mpie = e_mie;
            e_mie = 1'b0; e_priv = 2'b11;
            tag = (i_mret) ? "R8" : "R5";
        end else if (m) begin
            e_priv = e_mpp; e_mie = e_mpie; e_mpie = 1'b1; e_mpp = 2'b00;
            tag = "R7";
        end else if (w) begin
            if (i_sel == 2'd0) e_mepc = i_wd;
            else if (i_sel == 2'd1) begin
                e_mie  = i_wd[3];
                e_mpie = i_wd[7];
                e_mpp  = (i_wd[12:11] == 2'b10) ? 2'b00 : i_wd[12:11];
            end
            tag = "R9";
        end else if (i_we) begin
            tag = "R9";
        end
        chk_state(tag);
    endtask

    function automatic logic [31:0] status_word(input logic ie, input logic pie, input logic [1:0] pp);
        logic [31:0] v;
        v = 32'hFFFF_E776;  // unrelated bits set, field bits clear
        v[3] = ie; v[7] = pie; v[12:11] = pp;
        return v;
    endfunction

    // Watchdog: a hung run is a failed check.
    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [1:0] privs [3];
        privs[0] = 2'b00; privs[1] = 2'b01; privs[2] = 2'b11;
        rst_n = 1'b0; irq = 0; vld = 0; mret = 0; we = 0; sel = 0; wdata = 0; epc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        e_priv = 2'b11; e_mie = 0; e_mpie = 0; e_mpp = 2'b00; e_mepc = 0;
        #1;
        chk_state("R1");
        chk("R1 redirect", {31'd0, rv}, 32'd0);
        chk("R1 flush",    {31'd0, fl}, 32'd0);

        // R9: an unused select changes nothing.
        step(0, 0, 0, 1, 2'd3, 32'hFFFF_FFFF, 32'h0);

        for (int p = 0; p < 3; p++)
            for (int ie = 0; ie < 2; ie++)
                for (int pie = 0; pie < 2; pie++)
                    for (int pp = 0; pp < 4; pp++)
                        for (int ev = 0; ev < 16; ev++) begin
                            // Reach privilege privs[p] through a return.
                            step(0, 0, 0, 1, 2'd1, status_word(0, 0, privs[p]), 32'h0);
                            step(0, 0, 0, 1, 2'd0, 32'h0000_4000 + p * 16 + ev, 32'h0);
                            step(0, 1, 1, 0, 2'd0, 32'h0, 32'h0);
                            // Load the status fields under test.
                            step(0, 0, 0, 1, 2'd1, status_word(ie[0], pie[0], pp[1:0]), 32'h0);
                            step(0, 0, 0, 1, 2'd0, 32'h0000_8000 + ev * 4, 32'h0);
                            // Event mix: bit0 irq, bit1 valid, bit2 mret, bit3 write.
                            step(ev[0], ev[1], ev[2], ev[3], 2'd0, 32'hDEAD_0000,
                                 32'h0001_0000 + p * 64 + ev * 4);
                            // Follow-up return exercises the saved fields.
                            step(0, 1, 1, 0, 2'd0, 32'h0, 32'h0);
                        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule